// File: doc/BRIEF.md
# Memory-Operation Ordering Dispatcher

This block sits at the dispatch point of an out-of-order core's memory pipeline. Each cycle it is offered at most one operation, tagged as a plain load, a plain store, a load barrier, a store barrier, a full barrier or a non-memory operation. It looks up the occupancy of the load queue and the store queue and reports whether the operation fits. When the operation is accepted, the block gives it a fresh nonzero group identifier. In the same output cycle it sends out the dependency edges that tie this new group to the older groups it has to wait for.

Three tracking registers record the newest load group, the newest load-barrier group and the newest store group. Edges are derived only from those registers, from the operation kind and from a configuration input. When that input is set, the block assumes that loads never alias with stores. Queue entries are returned by retire pulses for loads and commit pulses for stores. A queue capacity of zero means that queue has no limit. The group state table that uses the create and edge commands sits outside this block.

Top module: `mem_order_dispatch`

## Requirements
- R1: After reset both queues are empty, no create or edge command is driven, all three tracking registers read as none (zero), and the first identifier handed out is 1.
- R2: `op_status` is 0 when the presented operation fits, 1 when it needs a load-queue entry and that queue is full, and 2 when it needs a store-queue entry and that queue is full. A full barrier with both queues full reports 1. Kind codes: 0 non-memory, 1 load, 2 store, 3 load barrier, 4 store barrier, 5 full barrier, and 6 and 7 are non-memory. A non-memory operation always reports 0.
- R3: A queue is full only when its capacity parameter is nonzero and its used count equals that capacity. With a capacity of zero the queue never reports full.
- R4: Loads and load barriers take one load-queue entry each. Stores and store barriers take one store-queue entry each. A full barrier takes one entry in each queue. `lq_retire` frees one load entry and `sq_commit` frees one store entry. A release while the queue is empty is ignored.
- R5: Each accepted memory operation receives the next identifier, one above the previous one. After the all-ones value the counter wraps to 1, so 0 is never used. Non-memory operations get no identifier and produce no create command.
- R6: A store or store barrier sends an edge from the newest store group (slot 0) and from the newest load group (slot 1), whatever the setting of `cfg_no_alias`.
- R7: A plain load sends an edge from the newest load-barrier group (slot 2). It sends an edge from the newest store group (slot 0) only when `cfg_no_alias` is 0. It never depends on an older plain load.
- R8: A load barrier sends an edge from the newest load group (slot 1) and from the newest load-barrier group (slot 2). It also sends one from the newest store group (slot 0) when `cfg_no_alias` is 0. A full barrier sends edges from all three slots.
- R9: A tracking register that reads zero sends no edge. A predecessor that has already appeared in a lower slot of the same command is not repeated in a higher slot.
- R10: Loads update the load register. Load barriers update the load and load-barrier registers. Stores and store barriers update the store register. Full barriers update all three.
- R11: The create command and its edges appear together one cycle after the accepting clock edge. The edge successor is always `grp_new_id`.
- R12: `op_ready` equals (`op_status` == 0). An operation offered while not ready changes no occupancy, no identifier and no tracking register, and it causes no create command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_no_alias | input | 1 | 1: loads are assumed not to alias with stores |
| op_valid | input | 1 | An operation is presented |
| op_kind | input | 3 | Operation kind code (see R2) |
| op_ready | output | 1 | The presented operation can be accepted this cycle |
| op_status | output | 2 | Availability status code |
| lq_retire | input | 1 | Frees one load-queue entry |
| sq_commit | input | 1 | Frees one store-queue entry |
| grp_new_valid | output | 1 | Create command for a new group |
| grp_new_id | output | GID_W | Identifier of the new group, also the edge successor |
| edge_valid | output | 3 | Per-slot edge valid: slot 0 store, slot 1 load, slot 2 load barrier |
| edge_pred | output | 3*GID_W | Per-slot predecessor identifier, slot i at bits [i*GID_W +: GID_W] |

## Verification
`op_status` and `op_ready` are combinational, so the bench reads them one time step after it drives an operation, before the accepting edge. Create and edge commands come out of a single register stage. The driver therefore pushes the expected command when it offers an accepted operation, and the monitor pops and compares it at the falling edge that follows the accepting rising edge. A command that shows up while nothing is expected counts as a failure, and this is how stalled offers and non-memory operations are checked. Occupancy effects appear in the status of the next offered operation, so fill, release and ignored-release cases are judged on the cycle in which that operation is presented.

// File: rtl/mord_pkg.sv
// Shared kind and status encodings for the memory ordering dispatcher.
// Assumes kind codes 6 and 7 are non-memory operations.
package mord_pkg;

    localparam logic [2:0] OPK_NONE  = 3'd0;
    localparam logic [2:0] OPK_LOAD  = 3'd1;
    localparam logic [2:0] OPK_STORE = 3'd2;
    localparam logic [2:0] OPK_LBAR  = 3'd3;
    localparam logic [2:0] OPK_SBAR  = 3'd4;
    localparam logic [2:0] OPK_FBAR  = 3'd5;

    typedef enum logic [1:0] {
        AV_OK      = 2'd0,
        AV_LQ_FULL = 2'd1,
        AV_SQ_FULL = 2'd2
    } avail_e;

    localparam int NUM_SLOTS = 3;
    localparam int SLOT_ST   = 0;
    localparam int SLOT_LD   = 1;
    localparam int SLOT_LB   = 2;

    // True when the kind occupies a load-queue entry.
    function automatic logic kind_uses_lq(input logic [2:0] k);
        return (k == OPK_LOAD) || (k == OPK_LBAR) || (k == OPK_FBAR);
    endfunction

    // True when the kind occupies a store-queue entry.
    function automatic logic kind_uses_sq(input logic [2:0] k);
        return (k == OPK_STORE) || (k == OPK_SBAR) || (k == OPK_FBAR);
    endfunction

endpackage

// File: rtl/mord_occupancy.sv
// Used-entry counter for one queue, with a full flag.
// SIZE == 0 means unbounded. Assumes that with an unbounded queue the
// consumer keeps the used count below 2**CNT_W.
module mord_occupancy #(
    parameter int SIZE  = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             give,
    output logic             full,
    output logic [CNT_W-1:0] used
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(SIZE);

    logic give_ok;

    // A release on an empty queue is dropped.
    assign give_ok = give && (used != '0);

    // Capacity comparison; zero capacity never reports full.
    assign full = (SIZE != 0) && (used == CAP);

    // Count update: acquire and release may happen in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            used <= '0;
        else if (take && !give_ok)
            used <= used + 1'b1;
        else if (!take && give_ok)
            used <= used - 1'b1;
    end
endmodule

// File: rtl/mord_id_alloc.sv
// Group identifier allocator: starts at 1, steps by one, skips 0 on wrap.
module mord_id_alloc #(
    parameter int GID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [GID_W-1:0] cur_id
);
    localparam logic [GID_W-1:0] FIRST_ID = GID_W'(1);

    // Next identifier register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_id <= FIRST_ID;
        else if (advance)
            cur_id <= (cur_id == '1) ? FIRST_ID : cur_id + 1'b1;
    end
endmodule

// File: rtl/mord_edge_gen.sv
// Combinational edge builder. It picks the predecessor slots for an operation
// kind, drops empty (zero) trackers and removes repeats of lower slots.
module mord_edge_gen
    import mord_pkg::*;
#(
    parameter int GID_W = 8
) (
    input  logic [2:0]                 kind,
    input  logic                       no_alias,
    input  logic [GID_W-1:0]           st_grp,
    input  logic [GID_W-1:0]           ld_grp,
    input  logic [GID_W-1:0]           lb_grp,
    output logic [NUM_SLOTS-1:0]       slot_vld,
    output logic [NUM_SLOTS*GID_W-1:0] slot_pred
);
    logic [NUM_SLOTS-1:0] want;
    logic [NUM_SLOTS-1:0] raw_vld;
    logic [GID_W-1:0]     pred [NUM_SLOTS];

    // Slot selection from the ordering rules.
    always_comb begin
        want[SLOT_ST] = kind_uses_sq(kind) || (kind_uses_lq(kind) && !no_alias);
        want[SLOT_LD] = kind_uses_sq(kind) || (kind == OPK_LBAR);
        want[SLOT_LB] = kind_uses_lq(kind);
        pred[SLOT_ST] = st_grp;
        pred[SLOT_LD] = ld_grp;
        pred[SLOT_LB] = lb_grp;
    end

    // Per-slot validity and duplicate removal against lower slots.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign raw_vld[s] = want[s] && (pred[s] != '0);
        assign slot_pred[s*GID_W +: GID_W] = pred[s];
        if (s == 0) begin : g_first
            assign slot_vld[s] = raw_vld[s];
        end else begin : g_rest
            logic [s-1:0] dup;
            for (genvar p = 0; p < s; p++) begin : g_cmp
                assign dup[p] = raw_vld[p] && (pred[p] == pred[s]);
            end
            assign slot_vld[s] = raw_vld[s] && !(|dup);
        end
    end
endmodule

// File: rtl/mem_order_dispatch.sv
// Memory ordering dispatcher top. It checks queue room for one operation per
// cycle, assigns group identifiers and emits create plus edge commands one
// cycle after acceptance. It assumes the downstream group table always takes
// commands (no back-pressure).
module mem_order_dispatch
    import mord_pkg::*;
#(
    parameter int LQ_SIZE = 8,
    parameter int SQ_SIZE = 8,
    parameter int GID_W   = 8,
    parameter int CNT_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_no_alias,
    input  logic                       op_valid,
    input  logic [2:0]                 op_kind,
    output logic                       op_ready,
    output logic [1:0]                 op_status,
    input  logic                       lq_retire,
    input  logic                       sq_commit,
    output logic                       grp_new_valid,
    output logic [GID_W-1:0]           grp_new_id,
    output logic [NUM_SLOTS-1:0]       edge_valid,
    output logic [NUM_SLOTS*GID_W-1:0] edge_pred
);
    localparam int PRED_W = NUM_SLOTS * GID_W;

    logic              need_lq, need_sq, is_mem, accept, mem_accept;
    logic              lq_full, sq_full;
    logic [CNT_W-1:0]  lq_used, sq_used;
    logic [GID_W-1:0]  cur_id;
    logic [GID_W-1:0]  st_grp, ld_grp, lb_grp;
    logic [NUM_SLOTS-1:0] nx_vld;
    logic [PRED_W-1:0] nx_pred;
    avail_e            status;

    // Queue needs of the presented kind.
    assign need_lq = kind_uses_lq(op_kind);
    assign need_sq = kind_uses_sq(op_kind);
    assign is_mem  = need_lq || need_sq;

    // Availability status: the load queue has priority over the store queue.
    always_comb begin
        if (need_lq && lq_full)
            status = AV_LQ_FULL;
        else if (need_sq && sq_full)
            status = AV_SQ_FULL;
        else
            status = AV_OK;
    end

    assign op_status  = status;
    assign op_ready   = (status == AV_OK);
    assign accept     = op_valid && op_ready;
    assign mem_accept = accept && is_mem;

    mord_occupancy #(.SIZE(LQ_SIZE), .CNT_W(CNT_W)) u_lq (
        .clk(clk), .rst_n(rst_n), .take(accept && need_lq),
        .give(lq_retire), .full(lq_full), .used(lq_used)
    );

    mord_occupancy #(.SIZE(SQ_SIZE), .CNT_W(CNT_W)) u_sq (
        .clk(clk), .rst_n(rst_n), .take(accept && need_sq),
        .give(sq_commit), .full(sq_full), .used(sq_used)
    );

    mord_id_alloc #(.GID_W(GID_W)) u_ids (
        .clk(clk), .rst_n(rst_n), .advance(mem_accept), .cur_id(cur_id)
    );

    mord_edge_gen #(.GID_W(GID_W)) u_edges (
        .kind(op_kind), .no_alias(cfg_no_alias),
        .st_grp(st_grp), .ld_grp(ld_grp), .lb_grp(lb_grp),
        .slot_vld(nx_vld), .slot_pred(nx_pred)
    );

    // Tracking registers for the newest load, load-barrier and store groups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_grp <= '0;
            ld_grp <= '0;
            lb_grp <= '0;
        end else if (mem_accept) begin
            if (need_lq)
                ld_grp <= cur_id;
            if ((op_kind == OPK_LBAR) || (op_kind == OPK_FBAR))
                lb_grp <= cur_id;
            if (need_sq)
                st_grp <= cur_id;
        end
    end

    // Output stage: create command and its edges leave together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_new_valid <= 1'b0;
            grp_new_id    <= '0;
            edge_valid    <= '0;
            edge_pred     <= '0;
        end else begin
            grp_new_valid <= mem_accept;
            edge_valid    <= mem_accept ? nx_vld : '0;
            if (mem_accept) begin
                grp_new_id <= cur_id;
                edge_pred  <= nx_pred;
            end
        end
    end
endmodule

// File: rtl/mord_checker.sv
// Property checker for the memory ordering dispatcher, bound to the top.
module mord_checker
    import mord_pkg::*;
#(
    parameter int LQ_SIZE = 8,
    parameter int SQ_SIZE = 8,
    parameter int GID_W   = 8,
    parameter int CNT_W   = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       op_valid,
    input logic [2:0]                 op_kind,
    input logic                       op_ready,
    input logic [1:0]                 op_status,
    input logic                       grp_new_valid,
    input logic [GID_W-1:0]           grp_new_id,
    input logic [NUM_SLOTS-1:0]       edge_valid,
    input logic [NUM_SLOTS*GID_W-1:0] edge_pred,
    input logic [CNT_W-1:0]           lq_used,
    input logic [CNT_W-1:0]           sq_used
);
    localparam logic [CNT_W-1:0] LQ_CAP = CNT_W'(LQ_SIZE);
    localparam logic [CNT_W-1:0] SQ_CAP = CNT_W'(SQ_SIZE);
    localparam logic             LQ_BOUNDED = (LQ_SIZE != 0);
    localparam logic             SQ_BOUNDED = (SQ_SIZE != 0);

    AST_LQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        LQ_BOUNDED |-> lq_used <= LQ_CAP); // R4
    AST_SQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        SQ_BOUNDED |-> sq_used <= SQ_CAP); // R4
    AST_FULL_LQ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (LQ_BOUNDED && lq_used == LQ_CAP && op_kind == OPK_LOAD)
        |-> (!op_ready && op_status == 2'd1)); // R3
    AST_CREATE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && (kind_uses_lq(op_kind) || kind_uses_sq(op_kind)))
        |=> grp_new_valid); // R11
    AST_NO_CREATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op_ready) |=> !grp_new_valid); // R12
    AST_ID_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        grp_new_valid |-> grp_new_id != '0); // R5
    AST_EDGE_WITH_CREATE: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_valid) |-> grp_new_valid); // R11

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_pred
        AST_PRED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
            edge_valid[s] |-> edge_pred[s*GID_W +: GID_W] != '0); // R9
    end
endmodule

bind mem_order_dispatch mord_checker #(
    .LQ_SIZE(LQ_SIZE), .SQ_SIZE(SQ_SIZE), .GID_W(GID_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_ready(op_ready), .op_status(op_status),
    .grp_new_valid(grp_new_valid), .grp_new_id(grp_new_id),
    .edge_valid(edge_valid), .edge_pred(edge_pred),
    .lq_used(lq_used), .sq_used(sq_used)
);

// File: tb/mem_order_dispatch_test.sv
`timescale 1ns/1ps
module mem_order_dispatch_test;
    localparam int LQS = 4;
    localparam int SQS = 3;
    localparam int GW  = 4;
    localparam int CW  = 8;

    typedef struct {
        logic [GW-1:0] id;
        logic [2:0]    ev;
        logic [GW-1:0] p [3];
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic no_alias = 1'b0;
    logic op_valid = 1'b0;
    logic [2:0] op_kind = 3'd0;
    logic lq_retire = 1'b0;
    logic sq_commit = 1'b0;
    logic op_ready, unb_ready;
    logic [1:0] op_status, unb_status;
    logic grp_new_valid, unb_nv;
    logic [GW-1:0] grp_new_id, unb_id;
    logic [2:0] edge_valid, unb_ev;
    logic [3*GW-1:0] edge_pred, unb_ep;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;
    exp_t exp_q [$];

    int m_lq, m_sq;
    logic [GW-1:0] m_next, m_st, m_ld, m_lb;

    always #4 clk = ~clk;

    mem_order_dispatch #(.LQ_SIZE(LQS), .SQ_SIZE(SQS), .GID_W(GW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_no_alias(no_alias), .op_valid(op_valid),
        .op_kind(op_kind), .op_ready(op_ready), .op_status(op_status),
        .lq_retire(lq_retire), .sq_commit(sq_commit), .grp_new_valid(grp_new_valid),
        .grp_new_id(grp_new_id), .edge_valid(edge_valid), .edge_pred(edge_pred)
    );

    mem_order_dispatch #(.LQ_SIZE(0), .SQ_SIZE(0), .GID_W(GW), .CNT_W(CW)) uut_unb (
        .clk(clk), .rst_n(rst_n), .cfg_no_alias(no_alias), .op_valid(op_valid),
        .op_kind(op_kind), .op_ready(unb_ready), .op_status(unb_status),
        .lq_retire(lq_retire), .sq_commit(sq_commit), .grp_new_valid(unb_nv),
        .grp_new_id(unb_id), .edge_valid(unb_ev), .edge_pred(unb_ep)
    );

    task automatic check(input string tag, input int act, input int expv, input string what);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic bit m_uses_lq(input logic [2:0] k);
        return k == 3'd1 || k == 3'd3 || k == 3'd5;
    endfunction
    function automatic bit m_uses_sq(input logic [2:0] k);
        return k == 3'd2 || k == 3'd4 || k == 3'd5;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        op_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_lq = 0; m_sq = 0; m_next = 1; m_st = 0; m_ld = 0; m_lb = 0;
        exp_q.delete();
    endtask

    // Driver: offers one operation, checks status, pushes the expected command.
    task automatic do_op(input logic [2:0] k, input string tag);
        int es;
        exp_t e;
        bit want [3];
        op_valid = 1'b1;
        op_kind = k;
        #1;
        es = 0;
        if (m_uses_lq(k) && m_lq == LQS) es = 1;
        else if (m_uses_sq(k) && m_sq == SQS) es = 2;
        check(tag, int'(op_status), es, "status");
        check(tag, int'(op_ready), (es == 0) ? 1 : 0, "ready");
        if (es == 0 && (m_uses_lq(k) || m_uses_sq(k))) begin
            want[0] = m_uses_sq(k) || (m_uses_lq(k) && !no_alias);
            want[1] = m_uses_sq(k) || k == 3'd3;
            want[2] = m_uses_lq(k);
            e.p[0] = m_st; e.p[1] = m_ld; e.p[2] = m_lb;
            e.ev[0] = want[0] && m_st != 0;
            e.ev[1] = want[1] && m_ld != 0 && !(e.ev[0] && m_ld == m_st);
            e.ev[2] = want[2] && m_lb != 0 && !(e.ev[0] && m_lb == m_st)
                      && !(e.ev[1] && m_lb == m_ld);
            e.id = m_next;
            e.tag = tag;
            exp_q.push_back(e);
            if (m_uses_lq(k)) begin m_ld = m_next; m_lq++; end
            if (k == 3'd3 || k == 3'd5) m_lb = m_next;
            if (m_uses_sq(k)) begin m_st = m_next; m_sq++; end
            m_next = (m_next == '1) ? GW'(1) : m_next + 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic release_q(input bit l, input bit s);
        lq_retire = l;
        sq_commit = s;
        @(posedge clk);
        @(negedge clk);
        lq_retire = 1'b0;
        sq_commit = 1'b0;
        if (l && m_lq > 0) m_lq--;
        if (s && m_sq > 0) m_sq--;
    endtask

    // Monitor: compares each create command against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && grp_new_valid) begin
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R12 unexpected create: actual id %0d expected none", grp_new_id);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, int'(grp_new_id), int'(e.id), "R5 group id");
                check(e.tag, int'(edge_valid), int'(e.ev), "edge valid");
                for (int s = 0; s < 3; s++)
                    if (e.ev[s])
                        check(e.tag, int'(edge_pred[s*GW +: GW]), int'(e.p[s]), "edge pred");
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1", int'(grp_new_valid), 0, "create after reset");
        check("R1", int'(edge_valid), 0, "edges after reset");
        op_kind = 3'd1;
        #1 check("R1", int'(op_ready), 1, "ready after reset");

        // Ordering rules, default alias assumption (R6 R7 R10 R11)
        do_op(3'd2, "R1 first store id");
        release_q(1, 1);
        do_op(3'd1, "R7 load after store");
        release_q(1, 1);
        do_op(3'd2, "R6 store after load");
        release_q(1, 1);
        // No-alias mode (R7 R8)
        no_alias = 1'b1;
        do_op(3'd1, "R7 load no-alias");
        release_q(1, 1);
        do_op(3'd3, "R8 load barrier no-alias");
        release_q(1, 1);
        do_op(3'd1, "R7 load after load barrier");
        release_q(1, 1);
        do_op(3'd2, "R6 store no-alias");
        release_q(1, 1);
        no_alias = 1'b0;
        do_op(3'd3, "R8 load barrier alias");
        release_q(1, 1);
        do_op(3'd4, "R6 store barrier");
        release_q(1, 1);
        do_op(3'd5, "R8 full barrier");
        release_q(1, 1);
        do_op(3'd2, "R9 store after full barrier dedup");
        release_q(1, 1);
        do_op(3'd5, "R9 full barrier dedup");
        release_q(1, 1);
        do_op(3'd0, "R5 non-memory no id");
        do_op(3'd7, "R2 code 7 non-memory");
        do_op(3'd1, "R10 load after non-memory");
        release_q(1, 1);

        // Occupancy and status (R2 R3 R4 R12)
        do_reset();
        for (int i = 0; i < LQS; i++) do_op(3'd1, "R4 fill load queue");
        op_valid = 1'b1; op_kind = 3'd1;
        #1 check("R3", int'(unb_ready), 1, "unbounded queue ready");
        op_valid = 1'b0;
        do_op(3'd1, "R3 load refused when full");
        do_op(3'd3, "R2 load barrier refused");
        for (int i = 0; i < SQS; i++) do_op(3'd2, "R4 fill store queue");
        do_op(3'd4, "R2 store barrier refused");
        do_op(3'd5, "R2 full barrier both full");
        do_op(3'd6, "R2 non-memory when full");
        release_q(1, 0);
        do_op(3'd2, "R12 store still refused");
        do_op(3'd5, "R2 full barrier store full");
        do_op(3'd1, "R4 load after retire");
        release_q(1, 1);
        do_op(3'd5, "R4 full barrier takes both");
        do_op(3'd1, "R4 load queue full again");
        do_op(3'd2, "R4 store queue full again");

        // Release on empty queue is ignored (R4)
        do_reset();
        release_q(1, 1);
        for (int i = 0; i < SQS; i++) do_op(3'd4, "R4 stores after empty release");
        do_op(3'd2, "R4 empty release ignored");

        // Identifier wrap (R5)
        do_reset();
        for (int i = 0; i < 17; i++) begin
            do_op(3'd2, "R5 id wrap");
            release_q(0, 1);
        end

        repeat (3) @(negedge clk);
        check("R11", exp_q.size(), 0, "pending commands");
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule